// File: doc/BRIEF.md
# Masked-Write GPIO Port

A 32-pin general-purpose I/O port reached through a single-cycle 32-bit register bus with no wait states. Each pin has a direction bit and an output latch; the pad side is modelled as an output-enable vector, an output-value vector and an input vector coming back from the pads.

Direction is never written as a whole word. One offset turns the selected pins into outputs and another turns them into inputs, so software touching one pin cannot disturb another. Output levels are written per half-port. In such a write the upper sixteen bits are a per-bit enable and the lower sixteen bits hold the new levels, so no read-modify-write is needed. Pad inputs pass through a two-flop synchronizer and can be read as one word. Reads are combinational on the address.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, or while rst_ni is low, every pin is an input (pad_oe_o = 0), every output latch is 0 (pad_out_o = 0), and the synchronized input word reads 0.
- R2: A write to offset 0x00 sets the direction bit of every pin whose write-data bit is 1, which makes it an output (pad_oe_o bit = 1). Pins whose write-data bit is 0 keep their direction.
- R3: A write to offset 0x04 clears the direction bit of every pin whose write-data bit is 1, which makes it an input. Pins whose write-data bit is 0 keep their direction. Reading offset 0x00 or 0x04 returns the direction word.
- R4: A write to offset 0x08 updates output pins 0..15, and a write to 0x0C updates pins 16..31. Bit 16+k of the write data enables pin k of that half, and bit k gives its new level.
- R5: In a half-port write, an output latch whose enable bit is 0 keeps its previous value.
- R6: The output latches are independent of direction. pad_out_o shows the latch value while a pin is an input, and a pin switched to output drives its latched level from the next cycle on.
- R7: Offset 0x10 reads the pad input word through a two-flop synchronizer. A pad change that is set up before a clock edge becomes readable after the second edge and not after the first.
- R8: Reading 0x08 returns the latches of pins 0..15 in bits 15:0, and reading 0x0C returns pins 16..31 in bits 15:0. The upper bits read 0 in both. Reads of any unmapped offset return 0.
- R9: Writes to offset 0x10 or to an unmapped offset change no direction bit and no output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| pad_i | input | 32 | Pad input levels, asynchronous |
| pad_oe_o | output | 32 | Per-pin output enable, 1 = drive |
| pad_out_o | output | 32 | Per-pin output level |

## Verification
The vector walk sets and clears overlapping pin groups, so it separates a real set or clear operation from a plain overwrite. It also drives half-port writes with full, partial and empty masks, which separates masked from unmasked bits and the low half from the high half. Outputs are latched while the pins are inputs and the direction is flipped afterwards, which shows that the latch and the enable are independent. Directed reads check the two-edge input latency against a one- or three-stage path, and check the zero-fill of unmapped and half-port readbacks. A reset in the middle of the run confirms the cleared state.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned NUM_PINS  = 32;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned HALF_W    = NUM_PINS / 2;
  localparam int unsigned NUM_HALF  = 2;
  localparam int unsigned SYNC_STG  = 2;

  localparam logic [ADDR_W-1:0] OFS_DIR_SET = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR_CLR = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_OUT_LO  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_OUT_HI  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_IN      = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR_SET,
    SEL_DIR_CLR,
    SEL_OUT_LO,
    SEL_OUT_HI,
    SEL_IN
  } reg_sel_e;
endpackage

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] dir_o
);
  logic [N-1:0] dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dir_q <= '0;
    else if (set_i)  dir_q <= dir_q | bits_i;
    else if (clr_i)  dir_q <= dir_q & ~bits_i;
  end

  assign dir_o = dir_q;
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int unsigned HALF_W   = 16,
  parameter int unsigned NUM_HALF = 2,
  localparam int unsigned N       = HALF_W * NUM_HALF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_HALF-1:0] wr_i,
  input  logic [HALF_W-1:0]   mask_i,
  input  logic [HALF_W-1:0]   val_i,
  output logic [N-1:0]        out_o
);
  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    logic [HALF_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= '0;
      else if (wr_i[h]) q <= (q & ~mask_i) | (val_i & mask_i);
    end
    assign out_o[h*HALF_W +: HALF_W] = q;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned N      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= (s == 0) ? async_i : stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o
);
  reg_sel_e            sel;
  logic [NUM_PINS-1:0] dir;
  logic [NUM_PINS-1:0] latch;
  logic [NUM_PINS-1:0] in_sync;
  logic [NUM_HALF-1:0] half_wr;

  always_comb begin
    unique case (bus_addr_i)
      OFS_DIR_SET: sel = SEL_DIR_SET;
      OFS_DIR_CLR: sel = SEL_DIR_CLR;
      OFS_OUT_LO:  sel = SEL_OUT_LO;
      OFS_OUT_HI:  sel = SEL_OUT_HI;
      OFS_IN:      sel = SEL_IN;
      default:     sel = SEL_NONE;
    endcase
  end

  assign half_wr[0] = bus_we_i && (sel == SEL_OUT_LO);
  assign half_wr[1] = bus_we_i && (sel == SEL_OUT_HI);

  gpio_dir_reg #(.N(NUM_PINS)) u_dir (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (bus_we_i && (sel == SEL_DIR_SET)),
    .clr_i  (bus_we_i && (sel == SEL_DIR_CLR)),
    .bits_i (bus_wdata_i[NUM_PINS-1:0]),
    .dir_o  (dir)
  );

  // upper half of the write word is the per-bit enable
  gpio_out_latch #(.HALF_W(HALF_W), .NUM_HALF(NUM_HALF)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (half_wr),
    .mask_i (bus_wdata_i[DATA_W-1 -: HALF_W]),
    .val_i  (bus_wdata_i[HALF_W-1:0]),
    .out_o  (latch)
  );

  gpio_in_sync #(.N(NUM_PINS), .STAGES(SYNC_STG)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_i),
    .sync_o  (in_sync)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (sel)
      SEL_DIR_SET, SEL_DIR_CLR: bus_rdata_o = dir;
      SEL_OUT_LO: bus_rdata_o[HALF_W-1:0] = latch[HALF_W-1:0];
      SEL_OUT_HI: bus_rdata_o[HALF_W-1:0] = latch[NUM_PINS-1 -: HALF_W];
      SEL_IN:     bus_rdata_o = in_sync;
      default:    bus_rdata_o = '0;
    endcase
  end

  assign pad_oe_o  = dir;
  assign pad_out_o = latch;
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
  import gpio_port_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [NUM_PINS-1:0] pad_i,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] pad_out_o
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cyc_q <= '0;
    else if (cyc_q != 2'd3)   cyc_q <= cyc_q + 2'd1;
  end

  logic wr_state;
  assign wr_state = bus_we_i && (bus_addr_i == OFS_DIR_SET || bus_addr_i == OFS_DIR_CLR ||
                                 bus_addr_i == OFS_OUT_LO  || bus_addr_i == OFS_OUT_HI);

  a_r1_reset_clear: assert property (@(posedge clk_i) !rst_ni |-> (pad_oe_o == '0 && pad_out_o == '0));

  a_r2_set_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFS_DIR_SET) |=>
      ((pad_oe_o & $past(bus_wdata_i)) == $past(bus_wdata_i)) &&
      ((pad_oe_o & ~$past(bus_wdata_i)) == ($past(pad_oe_o) & ~$past(bus_wdata_i))));

  a_r3_clr_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFS_DIR_CLR) |=>
      ((pad_oe_o & $past(bus_wdata_i)) == '0) &&
      ((pad_oe_o & ~$past(bus_wdata_i)) == ($past(pad_oe_o) & ~$past(bus_wdata_i))));

  a_r4_lo_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFS_OUT_LO) |=>
      (((pad_out_o[15:0] ^ $past(bus_wdata_i[15:0])) & $past(bus_wdata_i[31:16])) == '0));

  a_r5_lo_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFS_OUT_LO) |=>
      (((pad_out_o[15:0] ^ $past(pad_out_o[15:0])) & ~$past(bus_wdata_i[31:16])) == '0) &&
      $stable(pad_out_o[31:16]));

  a_r5_hi_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFS_OUT_HI) |=>
      (((pad_out_o[31:16] ^ $past(pad_out_o[31:16])) & ~$past(bus_wdata_i[31:16])) == '0) &&
      $stable(pad_out_o[15:0]));

  a_r7_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && bus_addr_i == OFS_IN) |-> (bus_rdata_o == $past(pad_i, 2)));

  a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i > OFS_IN || bus_addr_i[1:0] != 2'b00) |-> (bus_rdata_o == '0));

  a_r9_no_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_state |=> ($stable(pad_oe_o) && $stable(pad_out_o)));
endmodule

bind gpio_port_regs gpio_port_regs_chk u_chk (.*);

// File: tb/gpio_port_regs_test.sv
module gpio_port_regs_test;
  localparam time TCK = 4ns;

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp_oe;
    logic [31:0] exp_out;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 32'h0000_00FF, 32'h0000_00FF, 32'h0000_0000, 4'd2}, // R2 set
    '{8'h00, 32'h0000_0100, 32'h0000_01FF, 32'h0000_0000, 4'd2}, // R2 zeros keep
    '{8'h04, 32'h0000_000F, 32'h0000_01F0, 32'h0000_0000, 4'd3}, // R3 clear
    '{8'h08, 32'hFFFF_A5A5, 32'h0000_01F0, 32'h0000_A5A5, 4'd4}, // R4 low half
    '{8'h0C, 32'h00FF_1234, 32'h0000_01F0, 32'h0034_A5A5, 4'd4}, // R4 high half
    '{8'h08, 32'h000F_FFFF, 32'h0000_01F0, 32'h0034_A5AF, 4'd5}, // R5 partial mask
    '{8'h08, 32'h0000_0000, 32'h0000_01F0, 32'h0034_A5AF, 4'd5}, // R5 empty mask
    '{8'h04, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0034_A5AF, 4'd6}, // R6 all inputs
    '{8'h0C, 32'hFF00_AB00, 32'h0000_0000, 32'hAB34_A5AF, 4'd6}, // R6 latch while input
    '{8'h00, 32'hF000_0000, 32'hF000_0000, 32'hAB34_A5AF, 4'd6}, // R6 drive latched level
    '{8'h10, 32'hFFFF_FFFF, 32'hF000_0000, 32'hAB34_A5AF, 4'd9}, // R9 read-only offset
    '{8'h20, 32'hFFFF_FFFF, 32'hF000_0000, 32'hAB34_A5AF, 4'd9}  // R9 unmapped offset
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [31:0] pad_i = '0;
  logic [31:0] pad_oe_o;
  logic [31:0] pad_out_o;

  int checks = 0;
  int fails  = 0;

  always #(TCK/2) clk_i = ~clk_i;

  gpio_port_regs uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0; bus_addr_i = 8'h3C; bus_wdata_i = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #1;
    d = bus_rdata_o;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    check("R1 oe during reset", pad_oe_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 oe after reset", pad_oe_o, '0);
    check("R1 out after reset", pad_out_o, '0);
    bus_read(8'h10, rd); check("R1 input word after reset", rd, '0);

    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i].addr, VEC[i].wdata);
      check($sformatf("R%0d vector %0d oe", VEC[i].req, i), pad_oe_o, VEC[i].exp_oe);
      check($sformatf("R%0d vector %0d out", VEC[i].req, i), pad_out_o, VEC[i].exp_out);
    end

    bus_read(8'h04, rd); check("R3 read dir at clear offset", rd, 32'hF000_0000);
    bus_read(8'h00, rd); check("R3 read dir at set offset", rd, 32'hF000_0000);
    bus_read(8'h08, rd); check("R8 read low half", rd, 32'h0000_A5AF);
    bus_read(8'h0C, rd); check("R8 read high half", rd, 32'h0000_AB34);
    bus_read(8'h14, rd); check("R8 unmapped 0x14", rd, '0);
    bus_read(8'h02, rd); check("R8 unaligned 0x02", rd, '0);

    // R7: pad change before an edge, readable after the second edge only
    @(negedge clk_i);
    pad_i = 32'h5A5A_0F0F;
    bus_addr_i = 8'h10;
    @(negedge clk_i);
    check("R7 after one edge", bus_rdata_o, '0);
    @(negedge clk_i);
    check("R7 after two edges", bus_rdata_o, 32'h5A5A_0F0F);
    pad_i = 32'hFFFF_0000;
    @(negedge clk_i);
    check("R7 old value held one edge", bus_rdata_o, 32'h5A5A_0F0F);
    @(negedge clk_i);
    check("R7 new value", bus_rdata_o, 32'hFFFF_0000);

    // R1: reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 oe cleared by reset", pad_oe_o, '0);
    check("R1 out cleared by reset", pad_out_o, '0);
    bus_read(8'h10, rd); check("R1 input word cleared", rd, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(TCK * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule